// File: doc/BRIEF.md
# SPI Serial Memory Command Front End

This block is the serial side of a byte-wide 128K x 8 memory. It acts as an SPI slave: it takes one instruction per chip-select assertion, collects a 24-bit address, and then moves data bytes between the serial lines and a simple synchronous SRAM port. Reads and writes run as bursts. The address counter advances by one per byte and wraps at the top of the 17-bit space.

The serial pins are sampled by the system clock, so SCK must run well below that clock (at least four system clocks per SCK phase). A HOLD input pauses a transfer without ending the frame. Write permission and the busy state of nonvolatile operations are decided elsewhere and arrive here as two plain inputs. The tri-state output is split into a data bit and an output-enable.

Top module: `spi_mem_frontend`

## Requirements
- R1: While `spi_cs_n` is high, `spi_miso_oe` is 0. Activity on SCK and SI causes no SRAM access. After reset, `spi_miso_oe` and `sram_en` are 0.
- R2: Each selection carries one opcode: the first 8 SI bits after `spi_cs_n` falls, MSB first. Later bytes in the same frame are never decoded as opcodes, even when they equal an opcode value.
- R3: Opcode 0x03 (read) is followed by three address bytes, MSB first. Only the low 17 bits of those 24 bits form the address. Data is shifted out MSB first, and the first data bit appears on the SCK falling edge that follows the 24th address bit.
- R4: During a read, further bytes come from consecutive addresses for as long as `spi_cs_n` stays low.
- R5: Opcode 0x02 (write) is followed by three address bytes. Each following data byte, MSB first, goes to the next consecutive address.
- R6: During a burst, the address goes from 0x1FFFF to 0x00000.
- R7: A write byte reaches the SRAM only when all 8 of its bits have arrived, and only if `wr_permit` is 1 on its eighth rising SCK edge. A refused byte still moves the address on. A partial byte at the end of a frame is dropped.
- R8: If `nv_busy` is 1 when the opcode completes, a read or write opcode is refused for the rest of the frame. There is no SRAM access and `spi_miso_oe` stays 0.
- R9: Any opcode other than 0x02 and 0x03 makes the block ignore the rest of the frame: no SRAM access and no output drive.
- R10: When `spi_hold_n` is low while SCK is low, SCK edges are ignored and `spi_miso_oe` is 0. When `spi_hold_n` returns high while SCK is low, the transfer resumes where it stopped.
- R11: Both SCK idle levels work (SPI mode 0 and mode 3). SI is sampled on the rising SCK edge and SO changes on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause request, active low |
| wr_permit | input | 1 | High when array writes are allowed |
| nv_busy | input | 1 | High while a nonvolatile operation runs |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Drive enable for serial data out |
| sram_en | output | 1 | SRAM access strobe, one cycle |
| sram_we | output | 1 | SRAM write select |
| sram_addr | output | 17 | SRAM byte address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data, valid one cycle after a read strobe |

## Verification
A write commit shows up as an SRAM strobe one system clock after the SCK rising edge that completes the byte. The bench's monitor samples the SRAM port on falling system-clock edges, so each commit is caught during that one-cycle pulse and compared against the queue of expected writes. Read data changes within one system clock after an SCK falling edge. The driver samples SO four system clocks after each falling edge and just before the next rising edge, which leaves room for the two-cycle SRAM fetch and the output register. Refusals are checked as the absence of an output enable over every bit of a frame and as an SRAM access count that does not change.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPC_READ  = 8'h03;
    localparam logic [BYTE_W-1:0] OPC_WRITE = 8'h02;

    typedef enum logic [2:0] {
        ST_OPC    = 3'd0,
        ST_ADDR   = 3'd1,
        ST_RDATA  = 3'd2,
        ST_WDATA  = 3'd3,
        ST_IGNORE = 3'd4
    } fe_state_e;
endpackage

// File: rtl/spi_fe_sck_edge.sv
module spi_fe_sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic rise,
    output logic fall,
    output logic held
);
    logic sck_q;
    logic hold_q;
    logic hold_d;

    always_comb begin
        hold_d = hold_q;
        if (cs_n) begin
            hold_d = 1'b0;
        end else if (!sck) begin
            hold_d = !hold_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            sck_q  <= sck;
            hold_q <= hold_d;
        end
    end

    assign held = hold_q;
    assign rise = sck && !sck_q && !hold_q && !cs_n;
    assign fall = !sck && sck_q && !hold_q && !cs_n;

    // R10: a pause only starts or ends while SCK is low
    p_hold_change_sck_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && (hold_q != $past(hold_q))) |-> !$past(sck));
endmodule

// File: rtl/spi_fe_tx_shift.sv
module spi_fe_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift,
    output logic         so
);
    logic [W-1:0] tx_q, tx_d;
    logic         so_q, so_d;

    always_comb begin
        tx_d = tx_q;
        so_d = so_q;
        if (load) begin
            tx_d = load_data;
        end else if (shift) begin
            so_d = tx_q[W-1];
            tx_d = {tx_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            so_q <= 1'b0;
        end else begin
            tx_q <= tx_d;
            so_q <= so_d;
        end
    end

    assign so = so_q;

    // R11: the output bit only moves on a shift request
    p_so_moves_on_shift_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(shift) |-> $stable(so_q));
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
    import spi_fe_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int ADDR_BYTES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_hold_n,
    input  logic              wr_permit,
    input  logic              nv_busy,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              sram_en,
    output logic              sram_we,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [BYTE_W-1:0] sram_wdata,
    input  logic [BYTE_W-1:0] sram_rdata
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam int BCW   = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(BYTE_W - 1);
    localparam logic [BCW-1:0]   LAST_ABYTE = BCW'(ADDR_BYTES - 1);

    typedef struct packed {
        fe_state_e          state;
        logic               is_rd;
        logic [BIT_W-1:0]   bit_cnt;
        logic [BCW-1:0]     byte_cnt;
        logic [BYTE_W-1:0]  rx;
        logic [ADDR_W-1:0]  addr;
        logic               rd_req;
        logic               ld;
        logic               we;
        logic [ADDR_W-1:0]  req_addr;
        logic [BYTE_W-1:0]  wdata;
        logic [BIT_W-1:0]   ocnt;
        logic               so_live;
    } fe_regs_t;

    fe_regs_t q, d;
    logic     rise, fall, held;
    logic     tx_load, tx_shift;
    logic [BYTE_W-1:0] byte_in;
    logic [ADDR_W-1:0] addr_in;

    spi_fe_sck_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (spi_cs_n),
        .sck    (spi_sck),
        .hold_n (spi_hold_n),
        .rise   (rise),
        .fall   (fall),
        .held   (held)
    );

    spi_fe_tx_shift #(.W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_data (sram_rdata),
        .shift     (tx_shift),
        .so        (spi_miso)
    );

    assign byte_in = {q.rx[BYTE_W-2:0], spi_mosi};
    assign addr_in = ADDR_W'({q.addr, byte_in});

    always_comb begin
        d        = q;
        d.rd_req = 1'b0;
        d.we     = 1'b0;
        d.ld     = q.rd_req;
        tx_load  = q.ld;
        tx_shift = 1'b0;

        if (spi_cs_n) begin
            d.state    = ST_OPC;
            d.bit_cnt  = '0;
            d.byte_cnt = '0;
            d.ocnt     = '0;
            d.so_live  = 1'b0;
        end else begin
            if (rise) begin
                d.rx      = byte_in;
                d.bit_cnt = q.bit_cnt + 1'b1;
                if (q.bit_cnt == LAST_BIT) begin
                    unique case (q.state)
                        ST_OPC: begin
                            if (nv_busy) begin
                                d.state = ST_IGNORE;
                            end else if (byte_in == OPC_READ) begin
                                d.state = ST_ADDR;
                                d.is_rd = 1'b1;
                            end else if (byte_in == OPC_WRITE) begin
                                d.state = ST_ADDR;
                                d.is_rd = 1'b0;
                            end else begin
                                d.state = ST_IGNORE;
                            end
                        end
                        ST_ADDR: begin
                            d.addr = addr_in;
                            if (q.byte_cnt == LAST_ABYTE) begin
                                d.byte_cnt = '0;
                                if (q.is_rd) begin
                                    d.state    = ST_RDATA;
                                    d.rd_req   = 1'b1;
                                    d.req_addr = addr_in;
                                    d.addr     = addr_in + 1'b1;
                                end else begin
                                    d.state = ST_WDATA;
                                end
                            end else begin
                                d.byte_cnt = q.byte_cnt + 1'b1;
                            end
                        end
                        ST_WDATA: begin
                            if (wr_permit) begin
                                d.we       = 1'b1;
                                d.req_addr = q.addr;
                                d.wdata    = byte_in;
                            end
                            d.addr = q.addr + 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            if (fall && (q.state == ST_RDATA)) begin
                tx_shift  = 1'b1;
                d.so_live = 1'b1;
                d.ocnt    = q.ocnt + 1'b1;
                if (q.ocnt == LAST_BIT) begin
                    d.rd_req   = 1'b1;
                    d.req_addr = q.addr;
                    d.addr     = q.addr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sram_en     = q.rd_req || q.we;
    assign sram_we     = q.we;
    assign sram_addr   = q.req_addr;
    assign sram_wdata  = q.wdata;
    assign spi_miso_oe = q.so_live && (q.state == ST_RDATA) && !held && !spi_cs_n;

    // R1: no output drive while deselected
    p_hiz_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_miso_oe);

    // R1: every SRAM strobe stems from a selected cycle
    p_access_needs_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sram_en |-> $past(!spi_cs_n));

    // R7: a committed byte had permission on its completing cycle
    p_commit_permit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_en && sram_we) |-> $past(wr_permit));

    // R10: a pause drops the output drive
    p_hold_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !spi_miso_oe);

    // R10: a pause freezes the bit position
    p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !spi_cs_n) |=> $stable(q.bit_cnt));
endmodule

// File: tb/spi_mem_frontend_tb_top.sv
`timescale 1ns/1ps
module spi_mem_frontend_tb_top;
    logic clk = 1'b0;
    logic rst_n;
    logic spi_cs_n, spi_sck, spi_mosi, spi_hold_n, wr_permit, nv_busy;
    logic spi_miso, spi_miso_oe, sram_en, sram_we;
    logic [16:0] sram_addr;
    logic [7:0]  sram_wdata;
    logic [7:0]  sram_rdata;

    always #2.5 clk = ~clk;

    spi_mem_frontend dut_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_hold_n(spi_hold_n), .wr_permit(wr_permit),
        .nv_busy(nv_busy), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
    );

    function automatic logic [7:0] fill_val(int a);
        return a[7:0] ^ 8'h5A;
    endfunction

    // SRAM model with one cycle read latency
    logic [7:0] model_mem [int];
    initial sram_rdata = '0;
    always @(posedge clk) begin
        if (sram_en) begin
            if (sram_we) model_mem[int'(sram_addr)] = sram_wdata;
            else sram_rdata <= model_mem.exists(int'(sram_addr)) ?
                               model_mem[int'(sram_addr)] : fill_val(int'(sram_addr));
        end
    end

    typedef struct { int a; logic [7:0] d; } wr_item_t;
    wr_item_t   exp_q[$];
    logic [7:0] ref_mem [int];
    int n_cmp = 0, n_bad = 0, rd_seen = 0;
    bit cpol = 1'b0;

    function automatic logic [7:0] ref_rd(int a);
        return ref_mem.exists(a) ? ref_mem[a] : fill_val(a);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares SRAM commits against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && sram_en && sram_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected commit", int'(sram_addr), -1);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk(int'(sram_addr) == it.a, "R5 commit address", int'(sram_addr), it.a);
                chk(sram_wdata == it.d, "R5 commit data", int'(sram_wdata), int'(it.d));
            end
        end
        if (rst_n && sram_en && !sram_we) rd_seen++;
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b, output logic so_v, output logic oe_v);
        if (cpol) spi_sck = 1'b0;
        spi_mosi = b;
        wait_n(4);
        so_v = spi_miso;
        oe_v = spi_miso_oe;
        spi_sck = 1'b1;
        wait_n(4);
        if (!cpol) spi_sck = 1'b0;
    endtask

    task automatic do_hold();
        spi_hold_n = 1'b0;
        wait_n(3);
        chk(spi_miso_oe == 1'b0, "R10 drive off in pause", int'(spi_miso_oe), 0);
        for (int k = 0; k < 2; k++) begin
            spi_mosi = ~spi_mosi;
            spi_sck = 1'b1; wait_n(4);
            spi_sck = 1'b0; wait_n(4);
        end
        chk(spi_miso_oe == 1'b0, "R10 drive off after edges", int'(spi_miso_oe), 0);
        spi_hold_n = 1'b1;
        wait_n(3);
    endtask

    task automatic spi_byte(input logic [7:0] din, output logic [7:0] dout,
                            output bit oe_all, output bit oe_any, input int hold_at);
        logic s, o;
        oe_all = 1'b1; oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            if (i == hold_at) do_hold();
            spi_bit(din[i], s, o);
            dout[i] = s;
            oe_all &= o;
            oe_any |= o;
        end
    endtask

    task automatic frame_start(input bit mode3);
        cpol = mode3;
        spi_sck = mode3;
        wait_n(2);
        spi_cs_n = 1'b0;
        wait_n(4);
    endtask

    task automatic frame_end();
        wait_n(4);
        spi_cs_n = 1'b1;
        spi_sck = cpol;
        wait_n(8);
    endtask

    task automatic send_hdr(input logic [7:0] op, input logic [23:0] a24, output bit oe_any);
        logic [7:0] junk;
        bit al, an;
        oe_any = 1'b0;
        spi_byte(op, junk, al, an, -1);          oe_any |= an;
        spi_byte(a24[23:16], junk, al, an, -1);  oe_any |= an;
        spi_byte(a24[15:8], junk, al, an, -1);   oe_any |= an;
        spi_byte(a24[7:0], junk, al, an, -1);    oe_any |= an;
    endtask

    task automatic do_write(input bit mode3, input logic [23:0] a24, input logic [7:0] d [4],
                            input int n, input bit [3:0] permit, input int extra_bits);
        logic [7:0] junk;
        logic s, o;
        bit al, an, hoe;
        int a;
        a = int'(a24[16:0]);
        frame_start(mode3);
        send_hdr(8'h02, a24, hoe);
        chk(!hoe, "R1 no drive during write header", int'(hoe), 0);
        for (int k = 0; k < n; k++) begin
            wr_permit = permit[k];
            if (permit[k]) begin
                wr_item_t it;
                it.a = a; it.d = d[k];
                exp_q.push_back(it);
                ref_mem[a] = d[k];
            end
            spi_byte(d[k], junk, al, an, -1);
            a = (a + 1) & 32'h1FFFF;
        end
        wr_permit = 1'b1;
        for (int k = 0; k < extra_bits; k++) spi_bit(1'b1, s, o);
        frame_end();
    endtask

    task automatic do_read(input bit mode3, input logic [23:0] a24, input int n,
                           input int hold_at, input string req);
        logic [7:0] got;
        bit al, an, hoe;
        int a;
        a = int'(a24[16:0]);
        frame_start(mode3);
        send_hdr(8'h03, a24, hoe);
        for (int k = 0; k < n; k++) begin
            spi_byte(8'h00, got, al, an, (k == 0) ? hold_at : -1);
            chk(got == ref_rd(a), req, int'(got), int'(ref_rd(a)));
            chk(al, "R3 drive on during read data", int'(al), 1);
            a = (a + 1) & 32'h1FFFF;
        end
        frame_end();
    endtask

    task automatic finish_all();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        finish_all();
    end

    initial begin : main
        logic [7:0] d [4];
        logic [7:0] junk;
        logic s, o;
        bit al, an, hoe;
        int rd0;
        rst_n = 1'b0; spi_cs_n = 1'b1; spi_sck = 1'b0; spi_mosi = 1'b0;
        spi_hold_n = 1'b1; wr_permit = 1'b1; nv_busy = 1'b0;
        wait_n(5);
        chk(spi_miso_oe == 1'b0, "R1 reset drive off", int'(spi_miso_oe), 0);
        chk(sram_en == 1'b0, "R1 reset no access", int'(sram_en), 0);
        rst_n = 1'b1;
        wait_n(3);

        // R1: activity while deselected
        rd0 = rd_seen;
        an = 1'b0;
        for (int k = 0; k < 16; k++) begin
            spi_mosi = k[0]; spi_sck = ~spi_sck; wait_n(4);
            an |= spi_miso_oe;
        end
        spi_sck = 1'b0;
        wait_n(4);
        chk(!an, "R1 deselected drive", int'(an), 0);
        chk(rd_seen == rd0, "R1 deselected access", rd_seen, rd0);

        // R5 and R2: mode 0 burst write, data bytes equal to opcode values
        d = '{8'hA5, 8'h03, 8'h02, 8'h3C};
        do_write(1'b0, 24'hFE0010, d, 4, 4'b1111, 0);
        // R3 and R4: read back, upper address bits discarded
        do_read(1'b0, 24'h020010, 4, -1, "R4 burst read data");

        // R6 and R11: mode 3 write across the top of the address space
        d = '{8'h11, 8'h22, 8'h33, 8'h44};
        do_write(1'b1, 24'h01FFFE, d, 4, 4'b1111, 0);
        do_read(1'b1, 24'h01FFFF, 3, -1, "R6 wrapped read mode 3");

        // R7: refused byte and trailing partial byte
        d = '{8'hC1, 8'hC2, 8'hC3, 8'hC4};
        do_write(1'b0, 24'h000100, d, 3, 4'b1101, 5);
        do_read(1'b0, 24'h000100, 4, -1, "R7 permit and partial byte");

        // R8: busy refuses write and read
        nv_busy = 1'b1;
        rd0 = rd_seen;
        frame_start(1'b0);
        send_hdr(8'h02, 24'h000200, hoe);
        spi_byte(8'h77, junk, al, an, -1);
        frame_end();
        frame_start(1'b0);
        send_hdr(8'h03, 24'h000100, hoe);
        spi_byte(8'h00, junk, al, an, -1);
        frame_end();
        nv_busy = 1'b0;
        chk(!an && !hoe, "R8 busy read no drive", int'(an | hoe), 0);
        chk(rd_seen == rd0, "R8 busy no SRAM access", rd_seen, rd0);

        // R9: unknown opcode
        rd0 = rd_seen;
        frame_start(1'b1);
        send_hdr(8'h05, 24'h000010, hoe);
        spi_byte(8'h02, junk, al, an, -1);
        for (int k = 0; k < 3; k++) spi_bit(1'b0, s, o);
        frame_end();
        chk(!an && !hoe, "R9 unknown opcode no drive", int'(an | hoe), 0);
        chk(rd_seen == rd0, "R9 unknown opcode no access", rd_seen, rd0);

        // R10: pause in the middle of a read byte
        do_read(1'b0, 24'h000010, 2, 4, "R10 read across pause");

        wait_n(10);
        chk(exp_q.size() == 0, "R7 all expected commits seen", exp_q.size(), 0);
        finish_all();
    end
endmodule